// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a synthesizable two-wire bus target that behaves like a small byte-addressed nonvolatile memory. It holds its contents in an on-chip register array. SCL and SDA are brought into the system clock domain through synchronizers, and the block detects start and stop conditions on the synchronized lines. It checks the device-address byte against its hardwired select pins. It then serves byte and page writes, current-address reads, random reads and sequential reads. SDA is driven open-drain: the block only ever pulls the line low, through an output enable.

A write does not reach the array as it arrives. Data bytes collect in a one-page buffer, and the buffer is copied into the array only when a stop closes the write. A counter then imitates the timed programming cycle of a real part. While the counter runs, the block refuses its own address, so a host can poll until it gets an acknowledge.

A write-protect input freezes the array. The array size is a parameter from 256 to 2048 bytes, and it must be a power of two. Any word-address bits above eight are carried in the device-address byte.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A device-address byte is accepted only when its bits 7..4 are 1010. Bits 3..1 either match the select pins or act as upper word-address bits, depending on the array size. With 512 bytes, bits 3..2 must equal pins 2..1 and bit 1 is address bit 8. Bit 0 selects the direction: 1 is read, 0 is write. On a mismatch the block leaves SDA released during the ninth clock and ignores the bus until the next start.
- R2: For every byte the block accepts (device address, word address, data), it pulls SDA low for the whole ninth clock.
- R3: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start at any point, even in the middle of a byte, restarts reception of the device address.
- R4: In a write, the first byte after the device address is the word address. Each following data byte goes to the current address, and then only the low 4 address bits increment. Writes therefore wrap inside the 16-byte page, and a later byte overwrites an earlier one at the same location.
- R5: Buffered write data reaches the array only when a stop ends the write. If a start arrives first, the buffered bytes are discarded, and no busy cycle follows.
- R6: After a committed write, the block refuses its device address for WR_CYCLES clocks. After that it acknowledges again.
- R7: The address counter holds the last accessed address plus one, where a write's increment wraps within its page. A current-address read returns the byte at the counter.
- R8: In a read, each byte the host acknowledges is followed by the next byte. The address wraps from the last byte of the array to byte 0. A host NACK ends the read, and the block then leaves SDA released.
- R9: A write holding only a word address, followed by a repeated start and a read-mode device address, returns data starting at that word address.
- R10: If the write-protect input is high when the stop arrives, the data bytes are still acknowledged, but no array byte changes and no busy cycle starts.
- R11: The output enable (1 means pull SDA low, and a data bit of 1 means released) changes only while SCL is low.
- R12: After reset, SDA is released and the block is not busy, so it acknowledges its address at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_pins | input | 3 | Hardwired device select pins |
| wr_protect | input | 1 | High blocks all array writes |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The embedded assertions check, on every cycle, the rules that depend only on the state the block is in:
- SDA is never pulled while a device address is still arriving.
- SDA is released while the host answers a read byte.
- The output enable changes only with SCL low.
- No device-address acknowledge is given during a busy cycle.
- A write-protected stop never starts a busy cycle.

Data correctness can only be shown by the bench's scenarios:
- in-page wrap and overwrite,
- upper address bits carried in the address byte,
- wrap at the end of the array on reads,
- discard on a repeated start,
- the counter value seen by a current-address read,
- the length of the busy window as seen by polling.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK
    } st_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WORD,
        RX_DATA
    } rxk_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Upper select bits i (device bit i+1) compare with pins when i >= pb.
    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] pins, input int pb);
        logic ok;
        ok = (b[7:4] == DEV_TYPE);
        for (int i = 0; i < 3; i++) begin
            if (i >= pb && b[i+1] != pins[i]) ok = 1'b0;
        end
        return ok;
    endfunction

    // Join page bits from the address byte with the word byte.
    function automatic logic [10:0] join_addr(input logic [2:0] pg, input logic [7:0] w, input int pb);
        logic [10:0] full;
        full = {pg, w};
        for (int i = 0; i < 3; i++) begin
            if (i >= pb) full[8+i] = 1'b0;
        end
        return full;
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p;
    logic scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 20000,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_AW   = $clog2(PAGE_BYTES),
    localparam int BW        = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              commit,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic [7:0]                mem  [MEM_BYTES];
    logic [7:0]                pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]     pvalid;
    logic [ADDR_W-PAGE_AW-1:0] base_q;
    logic [BW-1:0]             busy_cnt;

    assign busy    = (busy_cnt != '0);
    assign rd_data = mem[rd_addr];

    // Page buffer and busy counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pvalid   <= '0;
            base_q   <= '0;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - BW'(1);
            if (buf_clr) pvalid <= '0;
            if (buf_we) begin
                pbuf[buf_addr[PAGE_AW-1:0]]   <= buf_data;
                pvalid[buf_addr[PAGE_AW-1:0]] <= 1'b1;
                base_q                        <= buf_addr[ADDR_W-1:PAGE_AW];
            end
            if (commit) begin
                pvalid <= '0;
                if (|pvalid && !wp && !busy) busy_cnt <= BW'(WR_CYCLES);
            end
        end
    end

    // Array update: all buffered bytes at once on a committing stop
    always_ff @(posedge clk) begin
        if (!rst && commit && |pvalid && !wp && !busy) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvalid[i]) mem[{base_q, PAGE_AW'(i)}] <= pbuf[i];
            end
        end
    end

    // R10: a protected stop never starts the busy window
    p_wp_nobusy_r10: assert property (@(posedge clk) disable iff (rst)
        (commit && wp && !busy) |=> !busy);
endmodule

// File: rtl/eep_proto.sv
module eep_proto
    import eep_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_AW   = $clog2(PAGE_BYTES),
    localparam int PB        = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        pins,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic              sda_pull,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              commit,
    output logic [ADDR_W-1:0] rd_addr
);
    st_e               st_q;
    rxk_e              kind_q;
    logic [7:0]        sh_q;
    logic [3:0]        cnt_q;
    logic              rd_q, hack_ok_q, oe_q;
    logic [2:0]        pg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [10:0]       word_full;

    assign word_full = join_addr(pg_q, sh_q, PB);
    assign sda_pull  = oe_q;
    assign rd_addr   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            kind_q    <= RX_DEV;
            sh_q      <= '0;
            cnt_q     <= '0;
            rd_q      <= 1'b0;
            hack_ok_q <= 1'b0;
            oe_q      <= 1'b0;
            pg_q      <= '0;
            addr_q    <= '0;
            buf_clr   <= 1'b0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_data  <= '0;
            commit    <= 1'b0;
        end else begin
            buf_we  <= 1'b0;
            buf_clr <= ev.start;
            commit  <= ev.stop;
            if (ev.start) begin
                st_q   <= ST_RX;
                kind_q <= RX_DEV;
                cnt_q  <= '0;
                oe_q   <= 1'b0;
            end else if (ev.stop) begin
                st_q <= ST_IDLE;
                oe_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_RX: begin
                        if (ev.rise && cnt_q < 4'd8) begin
                            sh_q  <= {sh_q[6:0], ev.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (ev.fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            case (kind_q)
                                RX_DEV: begin
                                    if (dev_match(sh_q, pins, PB) && !busy) begin
                                        rd_q <= sh_q[0];
                                        pg_q <= sh_q[3:1];
                                        oe_q <= 1'b1;
                                        st_q <= ST_ACK;
                                    end else begin
                                        st_q <= ST_IDLE;
                                    end
                                end
                                RX_WORD: begin
                                    addr_q <= word_full[ADDR_W-1:0];
                                    oe_q   <= 1'b1;
                                    st_q   <= ST_ACK;
                                end
                                default: begin
                                    buf_we   <= 1'b1;
                                    buf_addr <= addr_q;
                                    buf_data <= sh_q;
                                    addr_q   <= {addr_q[ADDR_W-1:PAGE_AW],
                                                 addr_q[PAGE_AW-1:0] + PAGE_AW'(1)};
                                    oe_q     <= 1'b1;
                                    st_q     <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            cnt_q <= '0;
                            if (kind_q == RX_DEV && rd_q) begin
                                st_q <= ST_TX;
                                sh_q <= rd_data;
                                oe_q <= ~rd_data[7];
                            end else begin
                                st_q   <= ST_RX;
                                oe_q   <= 1'b0;
                                kind_q <= (kind_q == RX_DEV) ? RX_WORD : RX_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (cnt_q == 4'd7) begin
                                oe_q   <= 1'b0;
                                addr_q <= addr_q + ADDR_W'(1);
                                st_q   <= ST_HACK;
                            end else begin
                                sh_q  <= {sh_q[6:0], 1'b0};
                                oe_q  <= ~sh_q[6];
                                cnt_q <= cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_HACK: begin
                        if (ev.rise) begin
                            hack_ok_q <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (hack_ok_q) begin
                                st_q  <= ST_TX;
                                sh_q  <= rd_data;
                                oe_q  <= ~rd_data[7];
                                cnt_q <= '0;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: never acknowledging a device address while the write cycle runs
    p_nack_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACK && kind_q == RX_DEV) |-> !busy);
    // R11: the pull changes only with SCL low
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> !ev.scl);
    // R1: SDA stays released while an address byte arrives
    p_addr_rx_free_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RX && kind_q == RX_DEV) |-> !oe_q);
    // R8: SDA released during the host's answer to a read byte
    p_hack_free_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HACK) |-> !oe_q);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter int MEM_BYTES   = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 20000,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(MEM_BYTES)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_pins,
    input  logic       wr_protect,
    output logic       sda_pull
);
    bus_ev_t           ev;
    logic              buf_clr, buf_we, commit, busy;
    logic [ADDR_W-1:0] buf_addr, rd_addr;
    logic [7:0]        buf_data, rd_data;

    eep_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    eep_proto #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) proto_i (
        .clk(clk), .rst(rst), .ev(ev), .pins(sel_pins), .busy(busy),
        .rd_data(rd_data), .sda_pull(sda_pull), .buf_clr(buf_clr),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .commit(commit), .rd_addr(rd_addr)
    );

    eep_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) store_i (
        .clk(clk), .rst(rst), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_data(buf_data), .commit(commit),
        .wp(wr_protect), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb_top;
    localparam int MEM = 512;
    localparam int WRC = 300;
    localparam int Q   = 6;
    localparam logic [2:0] PINS = 3'b110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic h_scl = 1'b1, h_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    wire  sda_line = h_sda & ~sda_pull;

    int total = 0, bad = 0, oe_bad = 0, mcur = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;
    logic [7:0] model [MEM];

    always #2.5 clk = ~clk;

    i2c_eeprom_target #(.MEM_BYTES(MEM), .PAGE_BYTES(16), .WR_CYCLES(WRC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .scl_i(h_scl), .sda_i(sda_line),
        .sel_pins(PINS), .wr_protect(wp), .sda_pull(sda_pull)
    );

    // R11 monitor: the pull must not change while the raw SCL is high
    always @(negedge clk) begin
        if (!rst && sda_pull !== oe_prev && h_scl) oe_bad++;
        oe_prev = sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q);
        h_sda = 1'b0; tick(Q); h_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        h_sda = 1'b0; tick(Q); h_scl = 1'b1; tick(Q);
        h_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b);
        h_sda = b; tick(Q); h_scl = 1'b1; tick(2*Q); h_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q); h_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] d);
        h_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); h_scl = 1'b1; tick(Q); d[i] = sda_line; tick(Q); h_scl = 1'b0;
        end
        tick(Q);
        h_sda = host_ack ? 1'b0 : 1'b1; tick(Q); h_scl = 1'b1; tick(2*Q); h_scl = 1'b0; tick(Q);
    endtask

    function automatic logic [7:0] dev(input logic p0, input logic rw);
        return {4'b1010, PINS[2], PINS[1], p0, rw};
    endfunction

    // Address-only write then stop, repeated until acknowledged
    task automatic poll(output int n);
        logic ack;
        n = 0;
        do begin
            i2c_start; send_byte(dev(1'b0, 1'b0), ack); i2c_stop; n++;
        end while (!ack && n < 12);
        if (!ack) n = 99;
    endtask

    task automatic wr_bytes(input int a, input int n, input int salt);
        logic ack;
        int polls, base, off;
        base = a - (a % 16);
        off  = a % 16;
        i2c_start;
        send_byte(dev(a[8], 1'b0), ack); chk(ack, "R1 write addr ack", ack, 1);
        send_byte(8'(a), ack);           chk(ack, "R2 word ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'((base + ((off + k) % 16)) * 37 + salt + k);
            send_byte(d, ack);
            chk(ack, wp ? "R10 protected data ack" : "R2 data ack", ack, 1);
            if (!wp) model[base + ((off + k) % 16)] = d;
        end
        i2c_stop;
        mcur = base + ((off + n) % 16);
        poll(polls);
        if (wp) chk(polls == 1, "R10 no busy after protected write", polls, 1);
        else chk(polls >= 2 && polls <= 4, "R6 busy polling", polls, 2);
    endtask

    task automatic rd_seq(input int a, input int n);
        logic ack;
        logic [7:0] d;
        i2c_start;
        send_byte(dev(a[8], 1'b0), ack); chk(ack, "R9 dummy write ack", ack, 1);
        send_byte(8'(a), ack);
        i2c_start;
        send_byte(dev(1'b0, 1'b1), ack); chk(ack, "R9 read addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(d == model[(a + k) % MEM], "R8 sequential data", d, model[(a + k) % MEM]);
        end
        chk(sda_pull == 1'b0, "R8 released after nack", sda_pull, 0);
        i2c_stop;
        mcur = (a + n) % MEM;
    endtask

    task automatic cur_read;
        logic ack;
        logic [7:0] d;
        i2c_start;
        send_byte(dev(1'b0, 1'b1), ack); chk(ack, "R7 read addr ack", ack, 1);
        recv_byte(1'b0, d);
        chk(d == model[mcur], "R7 current address data", d, model[mcur]);
        i2c_stop;
        mcur = (mcur + 1) % MEM;
    endtask

    initial begin
        logic ack;
        int polls;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        tick(10);
        rst = 1'b0;
        tick(4);
        chk(sda_pull == 1'b0, "R12 released after reset", sda_pull, 0);

        // R12: not busy out of reset
        i2c_start; send_byte(dev(1'b0, 1'b0), ack); i2c_stop;
        chk(ack, "R12 address ack after reset", ack, 1);

        // R1: select pin mismatch and wrong type nibble
        i2c_start; send_byte({4'b1010, ~PINS[2], PINS[1], 2'b00}, ack); i2c_stop;
        chk(!ack, "R1 pin mismatch nack", ack, 0);
        i2c_start; send_byte({4'b1011, PINS[2], PINS[1], 2'b00}, ack); i2c_stop;
        chk(!ack, "R1 type nibble nack", ack, 0);

        // R3: start in the middle of an address byte restarts reception
        i2c_start; send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_start; send_byte(dev(1'b0, 1'b0), ack); i2c_stop;
        chk(ack, "R3 restart mid byte", ack, 1);

        // Page sweep, including pages above 255 (page bit in address byte)
        wr_bytes(0, 16, 11);
        wr_bytes(16, 16, 12);
        wr_bytes(32, 16, 13);
        wr_bytes(272, 16, 14);
        wr_bytes(496, 16, 15);
        rd_seq(0, 16);
        rd_seq(272, 16);
        rd_seq(32, 16);

        // R8: read wraps from the end of the array to byte 0
        rd_seq(508, 8);
        // R7: counter sits after the last byte read
        cur_read;

        // R4: 20 bytes from offset 12 wrap in page 1 and overwrite
        wr_bytes(28, 20, 91);
        cur_read;
        rd_seq(16, 16);

        // R5: a start before the stop discards the buffered byte
        i2c_start;
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'd40, ack);
        send_byte(8'hAA, ack);
        i2c_start;
        send_byte(dev(1'b0, 1'b0), ack);
        i2c_stop;
        poll(polls);
        chk(polls == 1, "R5 no busy after discard", polls, 1);
        rd_seq(40, 1);

        // R10: write protect
        wp = 1'b1;
        wr_bytes(32, 4, 200);
        wp = 1'b0;
        rd_seq(32, 4);

        chk(oe_bad == 0, "R11 pull changed with SCL high", oe_bad, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule